// File: doc/BRIEF.md
# Repeating-Pattern Equalizer Adaptation Hold

This block sits on the parallel receive path of a serial transceiver. It looks for long runs of non-random data. A valid word counts as part of a repeating pattern when it equals the word received a selectable number of valid words earlier, at a distance of one to four words. While such words keep arriving, a run counter grows by the word width on each one. When the run exceeds the threshold for the selected equalizer variant, the block raises hold controls that freeze the decision-feedback equalizer's adaptation loops. This stops them drifting away from their ideal settings.

Two variants are supported. The five-tap variant freezes the gain loop and feedback taps H2 to H5 once the run passes 3000 bits. The seven-tap variant freezes the gain loop and taps H2 to H7 once it passes 4000 bits. Both thresholds are parameters. Short runs leave adaptation running. The holds are released only after a programmable number of consecutive non-matching words, so one stray mismatch does not make them toggle. In the linear (LPM) equalizer mode no hold is ever raised. A status flag still reports whether the run is above the threshold.

Top module: `eq_adapt_hold`

## Requirements
- R1: A valid word matches when it equals the valid word received `lag_sel`+1 valid words earlier (`lag_sel` = 0..3). A word with fewer earlier valid words than that distance since reset counts as a mismatch. Cycles with `rx_valid` low change no state, whatever the value of `rx_data`.
- R2: Each matching word adds DATA_W to the run counter, and each mismatching word clears it. The counter saturates at 2^RUN_W-1, where RUN_W = clog2(max(THR_FIVE,THR_SEVEN)+1)+1 (8191 with the defaults), so it never wraps.
- R3: With `seven_tap`=0 and `dfe_mode`=1, the holds assert when the run exceeds THR_FIVE (default 3000). A run of exactly THR_FIVE leaves them low.
- R4: With `seven_tap`=1 and `dfe_mode`=1, the holds assert when the run exceeds THR_SEVEN (default 4000). A run of exactly THR_SEVEN leaves them low.
- R5: In the five-tap variant an active hold drives `hold_gain` and `hold_tap[3:0]` high and keeps `hold_tap[5:4]` low. Bit k of `hold_tap` controls tap H(k+2).
- R6: In the seven-tap variant an active hold drives `hold_gain` and all six bits of `hold_tap` high (6'h3F).
- R7: Once asserted, the holds stay high until RELEASE_WORDS (default 4) consecutive mismatching valid words have arrived. Fewer consecutive mismatches, or invalid cycles, keep them high.
- R8: With `dfe_mode`=0 (LPM), all hold outputs are low at the next edge and stay low. The run counting and `rep_flag` continue.
- R9: `rep_flag` is high exactly when the run counter exceeds the threshold of the currently selected variant, regardless of `dfe_mode`.
- R10: All outputs are registered. A word updates the counters at the edge where it is sampled, and the outputs follow at the next edge. A synchronous reset (`rst` high) clears the history, the counters and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | DATA_W | Parallel receive word |
| rx_valid | input | 1 | Qualifies `rx_data` |
| lag_sel | input | LAG_W | Compare distance minus one (0..MAX_LAG-1) |
| dfe_mode | input | 1 | 1 = decision-feedback mode, 0 = linear mode |
| seven_tap | input | 1 | 1 = seven-tap variant, 0 = five-tap variant |
| hold_gain | output | 1 | Freeze for the gain adaptation loop |
| hold_tap | output | 6 | Freeze for taps H2..H7 (bit k = tap H(k+2)) |
| rep_flag | output | 1 | Run currently above the selected threshold |

## Verification
The bench builds the block with its default parameters: 20-bit words, four compare distances, thresholds of 3000 and 4000 bits and a release after four words. With these values, 150 and 200 matching words land a run exactly on each threshold, so the "exceeds" boundary is hit one word either side. A run of a few hundred words reaches the 8191-bit saturation point. It is chosen so that a wrapping counter would fall back below the threshold and drop `rep_flag`. The three-and-four mismatch release boundary and the distance-two and distance-three patterns are also reached within a few thousand cycles.

// File: rtl/eqh_pkg.sv
package eqh_pkg;

    localparam int HOLD_W = 7;   // bit 0 gain loop, bits 1..6 taps H2..H7

    typedef enum logic {
        VAR_FIVE  = 1'b0,
        VAR_SEVEN = 1'b1
    } eq_variant_e;

    function automatic logic [HOLD_W-1:0] tap_mask(eq_variant_e v);
        return (v == VAR_SEVEN) ? 7'h7F : 7'h1F;
    endfunction

endpackage

// File: rtl/eqh_match.sv
module eqh_match #(
    parameter int DATA_W  = 20,
    parameter int MAX_LAG = 4,
    localparam int LAG_W  = (MAX_LAG > 1) ? $clog2(MAX_LAG) : 1,
    localparam int FILL_W = $clog2(MAX_LAG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic [LAG_W-1:0]  lag_sel,
    output logic              word_match,
    output logic              word_miss
);

    typedef struct packed {
        logic [MAX_LAG-1:0][DATA_W-1:0] hist;
        logic [FILL_W-1:0]              fill;
    } match_st_t;

    match_st_t st_d, st_q;
    logic      equal;

    always_comb begin
        st_d  = st_q;
        equal = 1'b0;
        if (int'(lag_sel) < MAX_LAG) begin
            equal = (int'(st_q.fill) > int'(lag_sel)) && (st_q.hist[lag_sel] == rx_data);
        end
        if (rx_valid) begin
            st_d.hist[0] = rx_data;
            for (int i = 1; i < MAX_LAG; i++) begin
                st_d.hist[i] = st_q.hist[i-1];
            end
            if (int'(st_q.fill) < MAX_LAG) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_match = rx_valid && equal;
    assign word_miss  = rx_valid && !equal;

    // R1: without any history no word can match
    p_no_early_match_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.fill == '0) |-> !word_match);

    // R1: an invalid cycle leaves the history untouched
    p_idle_keeps_hist_r1: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(st_q.hist));

endmodule

// File: rtl/eqh_runs.sv
module eqh_runs #(
    parameter int DATA_W        = 20,
    parameter int RUN_W         = 13,
    parameter int RELEASE_WORDS = 4,
    localparam int MISS_W       = $clog2(RELEASE_WORDS + 1),
    localparam logic [RUN_W-1:0] RUN_MAX = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_match,
    input  logic              word_miss,
    output logic [RUN_W-1:0]  run_q,
    output logic [MISS_W-1:0] miss_q
);

    typedef struct packed {
        logic [RUN_W-1:0]  run;
        logic [MISS_W-1:0] miss;
    } runs_st_t;

    runs_st_t     st_d, st_q;
    logic [RUN_W:0] run_sum;

    always_comb begin
        st_d    = st_q;
        run_sum = {1'b0, st_q.run} + (RUN_W+1)'(DATA_W);
        if (word_match) begin
            st_d.run  = (run_sum > {1'b0, RUN_MAX}) ? RUN_MAX : run_sum[RUN_W-1:0];
            st_d.miss = '0;
        end else if (word_miss) begin
            st_d.run = '0;
            if (int'(st_q.miss) < RELEASE_WORDS) begin
                st_d.miss = st_q.miss + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_q  = st_q.run;
    assign miss_q = st_q.miss;

    // R2: a mismatch empties the run
    p_miss_clears_run_r2: assert property (@(posedge clk) disable iff (rst)
        word_miss |=> (run_q == '0));

    // R2: a full counter stays full on further matches
    p_run_saturates_r2: assert property (@(posedge clk) disable iff (rst)
        (word_match && run_q == RUN_MAX) |=> (run_q == RUN_MAX));

endmodule

// File: rtl/eqh_hold.sv
module eqh_hold
    import eqh_pkg::*;
#(
    parameter int RUN_W         = 13,
    parameter int THR_FIVE      = 3000,
    parameter int THR_SEVEN     = 4000,
    parameter int RELEASE_WORDS = 4,
    localparam int MISS_W       = $clog2(RELEASE_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dfe_mode,
    input  logic              seven_tap,
    input  logic [RUN_W-1:0]  run_q,
    input  logic [MISS_W-1:0] miss_q,
    output logic [HOLD_W-1:0] holds,
    output logic              rep_flag
);

    typedef struct packed {
        logic              active;
        logic              rep;
        logic [HOLD_W-1:0] holds;
    } hold_st_t;

    hold_st_t         st_d, st_q;
    eq_variant_e      variant;
    logic [RUN_W-1:0] thr;
    logic             over;

    always_comb begin
        variant = seven_tap ? VAR_SEVEN : VAR_FIVE;
        thr     = (variant == VAR_SEVEN) ? RUN_W'(THR_SEVEN) : RUN_W'(THR_FIVE);
        over    = run_q > thr;
        st_d    = st_q;
        st_d.rep = over;
        if (!dfe_mode) begin
            st_d.active = 1'b0;
        end else if (over) begin
            st_d.active = 1'b1;
        end else if (int'(miss_q) >= RELEASE_WORDS) begin
            st_d.active = 1'b0;
        end
        st_d.holds = st_d.active ? tap_mask(variant) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign holds    = st_q.holds;
    assign rep_flag = st_q.rep;

    // R8: linear mode silences every hold at the next edge
    p_lpm_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !dfe_mode |=> (holds == '0));

    // R5: five-tap variant never drives taps H6 and H7
    p_five_mask_r5: assert property (@(posedge clk) disable iff (rst)
        !seven_tap |=> (holds[6:5] == 2'b00));

    // R3: a run above threshold in feedback mode raises the gain hold
    p_set_on_long_run_r3: assert property (@(posedge clk) disable iff (rst)
        (dfe_mode && over) |=> holds[0]);

    // R7: enough consecutive misses with a short run release everything
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (!over && int'(miss_q) >= RELEASE_WORDS) |=> (holds == '0));

endmodule

// File: rtl/eq_adapt_hold.sv
module eq_adapt_hold
    import eqh_pkg::*;
#(
    parameter int DATA_W        = 20,
    parameter int MAX_LAG       = 4,
    parameter int THR_FIVE      = 3000,
    parameter int THR_SEVEN     = 4000,
    parameter int RELEASE_WORDS = 4,
    localparam int LAG_W   = (MAX_LAG > 1) ? $clog2(MAX_LAG) : 1,
    localparam int THR_MAX = (THR_FIVE > THR_SEVEN) ? THR_FIVE : THR_SEVEN,
    localparam int RUN_W   = $clog2(THR_MAX + 1) + 1,
    localparam int MISS_W  = $clog2(RELEASE_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic [LAG_W-1:0]  lag_sel,
    input  logic              dfe_mode,
    input  logic              seven_tap,
    output logic              hold_gain,
    output logic [5:0]        hold_tap,
    output logic              rep_flag
);

    logic              word_match;
    logic              word_miss;
    logic [RUN_W-1:0]  run_q;
    logic [MISS_W-1:0] miss_q;
    logic [HOLD_W-1:0] holds;

    eqh_match #(
        .DATA_W  (DATA_W),
        .MAX_LAG (MAX_LAG)
    ) u_match (
        .clk        (clk),
        .rst        (rst),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .lag_sel    (lag_sel),
        .word_match (word_match),
        .word_miss  (word_miss)
    );

    eqh_runs #(
        .DATA_W        (DATA_W),
        .RUN_W         (RUN_W),
        .RELEASE_WORDS (RELEASE_WORDS)
    ) u_runs (
        .clk        (clk),
        .rst        (rst),
        .word_match (word_match),
        .word_miss  (word_miss),
        .run_q      (run_q),
        .miss_q     (miss_q)
    );

    eqh_hold #(
        .RUN_W         (RUN_W),
        .THR_FIVE      (THR_FIVE),
        .THR_SEVEN     (THR_SEVEN),
        .RELEASE_WORDS (RELEASE_WORDS)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .dfe_mode  (dfe_mode),
        .seven_tap (seven_tap),
        .run_q     (run_q),
        .miss_q    (miss_q),
        .holds     (holds),
        .rep_flag  (rep_flag)
    );

    assign hold_gain = holds[0];
    assign hold_tap  = holds[6:1];

    // R10: reset leaves every output low at the following edge
    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (!hold_gain && hold_tap == '0 && !rep_flag));

endmodule

// File: tb/eq_adapt_hold_tb_top.sv
module eq_adapt_hold_tb_top;

    localparam int W       = 20;
    localparam int THR5    = 3000;
    localparam int THR7    = 4000;
    localparam int REL     = 4;
    localparam int RUN_MAX = (1 << ($clog2(THR7 + 1) + 1)) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] rx_data = '0;
    logic         rx_valid = 1'b0;
    logic [1:0]   lag_sel = 2'd0;
    logic         dfe_mode = 1'b1;
    logic         seven_tap = 1'b0;
    logic         hold_gain;
    logic [5:0]   hold_tap;
    logic         rep_flag;

    always #10 clk = ~clk;   // 50 MHz

    eq_adapt_hold dut_i (
        .clk       (clk),
        .rst       (rst),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .lag_sel   (lag_sel),
        .dfe_mode  (dfe_mode),
        .seven_tap (seven_tap),
        .hold_gain (hold_gain),
        .hold_tap  (hold_tap),
        .rep_flag  (rep_flag)
    );

    int checks = 0;
    int fails  = 0;
    string phase = "R10";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural reference
    logic [W-1:0] m_hist[$];
    int  m_run = 0, m_miss = 0;
    bit  m_active = 0, m_rep = 0;
    logic [5:0] m_tap = '0;
    bit  started = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_hist.delete();
            m_run = 0; m_miss = 0; m_active = 0; m_rep = 0; m_tap = '0;
        end else begin
            int thr;
            bit hit;
            thr   = seven_tap ? THR7 : THR5;
            m_rep = (m_run > thr);
            if (!dfe_mode)           m_active = 0;
            else if (m_run > thr)    m_active = 1;
            else if (m_miss >= REL)  m_active = 0;
            m_tap = m_active ? (seven_tap ? 6'h3F : 6'h0F) : 6'h00;
            if (rx_valid) begin
                hit = (m_hist.size() > int'(lag_sel)) && (m_hist[lag_sel] == rx_data);
                if (hit) begin
                    m_run  = (m_run + W > RUN_MAX) ? RUN_MAX : m_run + W;
                    m_miss = 0;
                end else begin
                    m_run  = 0;
                    m_miss = (m_miss < REL) ? m_miss + 1 : REL;
                end
                m_hist.push_front(rx_data);
                if (m_hist.size() > 4) void'(m_hist.pop_back());
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(hold_gain === m_active, phase, "hold_gain vs model", {7'd0, hold_gain}, {7'd0, m_active});
            chk(hold_tap === m_tap, phase, "hold_tap vs model", {2'd0, hold_tap}, {2'd0, m_tap});
            chk(rep_flag === m_rep, {phase, " R9"}, "rep_flag vs model", {7'd0, rep_flag}, {7'd0, m_rep});
        end
    end

    int uniq = 0;
    task automatic send(input logic [W-1:0] d);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = d;
    endtask
    task automatic send_new();
        uniq++;
        send(W'(32'h5A000 + uniq * 37));
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_data  = W'(32'hF0F0F + i * 113);
        end
    endtask
    task automatic expect_out(input bit g, input logic [5:0] t, input bit r, input string req);
        chk(hold_gain === g, req, "hold_gain", {7'd0, hold_gain}, {7'd0, g});
        chk(hold_tap === t, req, "hold_tap", {2'd0, hold_tap}, {2'd0, t});
        chk(rep_flag === r, req, "rep_flag", {7'd0, rep_flag}, {7'd0, r});
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out(0, 6'h00, 0, "R10 reset state");

        // five-tap, distance one: exactly 3000 bits then one word more
        phase = "R3";
        lag_sel = 2'd0; seven_tap = 1'b0; dfe_mode = 1'b1;
        send_new();
        for (int i = 0; i < 151; i++) send(20'hAAAAA);
        idle(2);
        expect_out(0, 6'h00, 0, "R3 run of exactly 3000");
        send(20'hAAAAA);
        idle(2);
        expect_out(1, 6'h0F, 1, "R3 R5 run of 3020");

        // invalid cycles with garbage data touch nothing
        phase = "R1";
        idle(6);
        expect_out(1, 6'h0F, 1, "R1 idle cycles");

        // release hysteresis
        phase = "R7";
        for (int i = 0; i < 3; i++) send_new();
        idle(2);
        expect_out(1, 6'h0F, 0, "R7 three misses keep hold");
        send_new();
        idle(2);
        expect_out(0, 6'h00, 0, "R7 fourth miss releases");

        // seven-tap, distance three
        phase = "R4";
        seven_tap = 1'b1; lag_sel = 2'd2;
        for (int i = 0; i < 203; i++) send(W'(32'h11111 * (i % 3 + 1)));
        idle(2);
        expect_out(0, 6'h00, 0, "R4 run of exactly 4000");
        send(W'(32'h11111 * (203 % 3 + 1)));
        idle(2);
        expect_out(1, 6'h3F, 1, "R4 R6 run of 4020");

        // linear mode
        phase = "R8";
        dfe_mode = 1'b0;
        idle(1);
        idle(1);
        expect_out(0, 6'h00, 1, "R8 linear mode drops holds");
        dfe_mode = 1'b1;
        idle(2);
        expect_out(1, 6'h3F, 1, "R8 feedback mode resumes hold");

        // saturation: a wrapping counter would land at 8 bits
        phase = "R2";
        for (int i = 204; i < 204 + 209; i++) send(W'(32'h11111 * (i % 3 + 1)));
        idle(2);
        expect_out(1, 6'h3F, 1, "R2 saturated run stays above threshold");

        // release, then distance two with an isolated break
        for (int i = 0; i < 4; i++) send_new();
        seven_tap = 1'b0; lag_sel = 2'd1;
        for (int i = 0; i < 142; i++) send((i % 2 == 0) ? 20'h0C0C0 : 20'h30303);
        send(20'h77777);
        for (int i = 0; i < 142; i++) send((i % 2 == 0) ? 20'h0C0C0 : 20'h30303);
        idle(2);
        expect_out(0, 6'h00, 0, "R2 break restarts run");

        // reset while held
        phase = "R10";
        for (int i = 0; i < 160; i++) send(20'h0C0C0 ^ W'(i % 2));
        idle(2);
        expect_out(1, 6'h0F, 1, "R5 distance-two hold");
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        idle(1);
        expect_out(0, 6'h00, 0, "R10 reset clears holds");

        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule